// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical page by walking a two-level page table held in memory. It accepts one translation request at a time and reads the directory entry. It then reads the table entry, unless the directory entry maps a 4 MB page. It sets the accessed and dirty flags in memory where they change. The walk ends with a one-cycle result pulse that carries either a page base, a size flag and permissions, or a page-fault error code together with the faulting address.

The caller supplies the translation controls with each request: a paging enable, a supervisor write-protect enable, a large-page enable, the directory base and an address mask that can force physical bit 20 low. The block latches them when it accepts the request. Memory is reached through a single port with a request/valid handshake. The port carries both the entry reads and the write-backs. A translation cache and the delivery of the fault to an exception unit sit outside the block.

Top module: `pgwalk_top`

## Requirements
- R1: With `pagingOn` low, an accepted request completes without any memory access. The result is a 4 KB page at `reqAddr` with bits 11:0 cleared, ANDed with `a20Mask`, with both `permWrite` and `permUser` set.
- R2: The first read of a walk goes to `dirBase` with bits 11:0 cleared, plus four times linear bits 31:22, all ANDed with `a20Mask`.
- R3: A directory entry with bit 7 set, read while `pseOn` is high, ends the walk as a 4 MB page (`bigPage`=1). Its base is entry bits 31:22, masked by `a20Mask`, and its permissions come from that entry alone.
- R4: Otherwise the second read goes to the directory entry's bits 31:12 (low 12 bits cleared) plus four times linear bits 21:12, masked by `a20Mask`. The result page is table entry bits 31:12, masked by `a20Mask`, with `bigPage`=0.
- R5: An entry with bit 0 (present) clear, at either level, ends the walk as a fault with error code bit 0 equal to 0.
- R6: The effective user bit (bit 2) and writable bit (bit 1) are the AND of both levels. A user access without the user bit, or a user write without the writable bit, faults with error code bit 0 equal to 1.
- R7: A supervisor write to a page whose writable bit is clear faults only while `wpOn` is high.
- R8: On a 4 KB walk, a directory entry with bit 5 (accessed) clear is written back with bit 5 set before the table read. When bit 5 is already set, nothing is written.
- R9: The leaf entry is written back with bit 5 set, and with bit 6 (dirty) also set on a write, only if this changes its value.
- R10: The fault error code carries the request's write flag in bit 1 and its user flag in bit 2. `faultAddr` returns the full linear address of the request.
- R11: `permWrite` is set in a paged result only if the leaf's dirty bit is set after the walk and a write of the same privilege would pass the checks of R6 and R7.
- R12: `reqReady` is high only when idle. Each memory access holds `memReq` and `memAddr` until `memValid`. `doneValid` rises the cycle after the last access completes and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block idle, request accepted |
| reqAddr | input | 32 | Linear address |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is from user privilege |
| pagingOn | input | 1 | Paging enable |
| wpOn | input | 1 | Supervisor write-protect enable |
| pseOn | input | 1 | 4 MB page enable |
| dirBase | input | 32 | Page directory base address |
| a20Mask | input | 32 | Physical address mask |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write-back |
| memAddr | output | 32 | Entry address |
| memWdata | output | 32 | Write-back data |
| memValid | input | 1 | Access complete |
| memRdata | input | 32 | Entry read data |
| doneValid | output | 1 | Result pulse |
| doneFault | output | 1 | Result is a page fault |
| physPage | output | 32 | Physical page base |
| bigPage | output | 1 | Result is a 4 MB page |
| permWrite | output | 1 | Writes allowed on this mapping |
| permUser | output | 1 | User accesses allowed on this mapping |
| faultCode | output | 3 | Error code: present, write, user |
| faultAddr | output | 32 | Linear address of the request |

## Verification
A request is taken at the clock edge where `reqValid` meets `reqReady`. With the bench's one-cycle memory, every entry access costs exactly two cycles. So the result pulse is due N*2 edges after acceptance, where N is the number of reads and write-backs that the requirements call for. For a flat translation N is 0, and the pulse appears right after the accepting edge. The bench computes N for every request from its own walk model. It counts edges from acceptance until `doneValid`, samples one time unit after each edge, and checks the count against 2*N. It checks the result fields and the written-back memory words in that same cycle.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ADDR_W = 32;
  localparam int PG_SH  = 12;          // 4 KB page offset width
  localparam int BIG_SH = 22;          // 4 MB page offset width
  localparam int ENT_SH = 2;           // bytes per entry = 1 << ENT_SH
  localparam int ERR_W  = 3;

  // Entry flag positions (decoded by memory-resident tables)
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_U  = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;

  localparam logic [ADDR_W-1:0] SMALL_MASK = ~((ADDR_W'(1) << PG_SH) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] BIG_MASK   = ~((ADDR_W'(1) << BIG_SH) - ADDR_W'(1));

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_WB_DIR, ST_RD_TBL, ST_WB_TBL, ST_DONE, ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic accept;    // request latched this cycle
    logic flat;      // paging off: flat result
    logic capDir;    // directory entry arriving
    logic capTbl;    // table entry arriving
    logic tblPhase;  // table level selected
  } walkStrobe_t;

  typedef struct packed {
    logic present;
    logic big;
    logic permFail;
    logic leafWb;
    logic dirWb;
  } walkStatus_t;
endpackage

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       stb,
  output walkStatus_t       sts,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              wpOn,
  input  logic              pseOn,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] a20Mask,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [ADDR_W-1:0] physPage,
  output logic              bigPage,
  output logic              permWrite,
  output logic              permUser,
  output logic [ERR_W-1:0]  faultCode,
  output logic [ADDR_W-1:0] faultAddr
);
  localparam int DIR_IDX_W = ADDR_W - BIG_SH;
  localparam int TBL_IDX_W = BIG_SH - PG_SH;

  logic [ADDR_W-1:0] linAddr, dirAddr, tblAddr, wbData, resPage, maskLat;
  logic isWr, isUsr, wpLat, pseLat, dirU, dirRW, presentLat;
  logic resBig, resPW, resPU;

  logic rdBig, leafSel, effU, effRW, wrOk;
  logic [ADDR_W-1:0] wbNext, pageMask, nextTbl, dirOfs, tblOfs, newDir;

  always_comb begin
    rdBig    = !stb.tblPhase && memRdata[B_PS] && pseLat;
    leafSel  = stb.tblPhase || rdBig;
    effU     = memRdata[B_U]  & (stb.tblPhase ? dirU  : 1'b1);
    effRW    = memRdata[B_RW] & (stb.tblPhase ? dirRW : 1'b1);
    wrOk     = isUsr ? (effU & effRW) : (effRW | ~wpLat);
    wbNext   = memRdata | (ADDR_W'(1) << B_A)
             | ((leafSel && isWr) ? (ADDR_W'(1) << B_D) : '0);
    pageMask = rdBig ? BIG_MASK : SMALL_MASK;
    dirOfs   = ADDR_W'({reqAddr[ADDR_W-1 -: DIR_IDX_W], {ENT_SH{1'b0}}});
    tblOfs   = ADDR_W'({linAddr[BIG_SH-1 -: TBL_IDX_W], {ENT_SH{1'b0}}});
    newDir   = ((dirBase & SMALL_MASK) + dirOfs) & a20Mask;
    nextTbl  = ((memRdata & SMALL_MASK) + tblOfs) & maskLat;

    sts.present  = memRdata[B_P];
    sts.big      = rdBig;
    sts.permFail = (isUsr && !effU) || (isWr && !wrOk);
    sts.leafWb   = wbNext != memRdata;
    sts.dirWb    = !memRdata[B_A];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linAddr <= '0; dirAddr <= '0; tblAddr <= '0; wbData <= '0;
      maskLat <= '0; resPage <= '0;
      isWr <= 1'b0; isUsr <= 1'b0; wpLat <= 1'b0; pseLat <= 1'b0;
      dirU <= 1'b0; dirRW <= 1'b0; presentLat <= 1'b0;
      resBig <= 1'b0; resPW <= 1'b0; resPU <= 1'b0;
    end else begin
      if (stb.accept) begin
        linAddr <= reqAddr;
        isWr    <= reqWrite;
        isUsr   <= reqUser;
        wpLat   <= wpOn;
        pseLat  <= pseOn;
        maskLat <= a20Mask;
        dirAddr <= newDir;
        if (stb.flat) begin
          resPage    <= reqAddr & SMALL_MASK & a20Mask;
          resBig     <= 1'b0;
          resPW      <= 1'b1;
          resPU      <= 1'b1;
          presentLat <= 1'b1;
        end
      end
      if (stb.capDir) begin
        dirU    <= memRdata[B_U];
        dirRW   <= memRdata[B_RW];
        tblAddr <= nextTbl;
      end
      if (stb.capDir || stb.capTbl) begin
        wbData     <= wbNext;
        presentLat <= memRdata[B_P];
        resPage    <= memRdata & pageMask & maskLat;
        resBig     <= rdBig;
        resPW      <= wbNext[B_D] & wrOk;
        resPU      <= effU;
      end
    end
  end

  assign memAddr   = stb.tblPhase ? tblAddr : dirAddr;
  assign memWdata  = wbData;
  assign physPage  = resPage;
  assign bigPage   = resBig;
  assign permWrite = resPW;
  assign permUser  = resPU;
  assign faultCode = {isUsr, isWr, presentLat};
  assign faultAddr = linAddr;
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        pagingOn,
  input  logic        memValid,
  input  walkStatus_t sts,
  output walkStrobe_t stb,
  output logic        memReq,
  output logic        memWe,
  output logic        reqReady,
  output logic        doneValid,
  output logic        doneFault
);
  walkState_t state, nxt;
  logic dirLeaf;

  always_comb begin
    stb.accept   = (state == ST_IDLE) && reqValid;
    stb.flat     = stb.accept && !pagingOn;
    stb.capDir   = (state == ST_RD_DIR) && memValid;
    stb.capTbl   = (state == ST_RD_TBL) && memValid;
    stb.tblPhase = (state == ST_RD_TBL) || (state == ST_WB_TBL);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (reqValid) nxt = pagingOn ? ST_RD_DIR : ST_DONE;
      ST_RD_DIR: if (memValid) begin
        if (!sts.present)      nxt = ST_FAULT;
        else if (sts.big) begin
          if (sts.permFail)    nxt = ST_FAULT;
          else if (sts.leafWb) nxt = ST_WB_DIR;
          else                 nxt = ST_DONE;
        end else               nxt = sts.dirWb ? ST_WB_DIR : ST_RD_TBL;
      end
      ST_WB_DIR: if (memValid) nxt = dirLeaf ? ST_DONE : ST_RD_TBL;
      ST_RD_TBL: if (memValid) begin
        if (!sts.present || sts.permFail) nxt = ST_FAULT;
        else if (sts.leafWb)              nxt = ST_WB_TBL;
        else                              nxt = ST_DONE;
      end
      ST_WB_TBL: if (memValid) nxt = ST_DONE;
      ST_DONE, ST_FAULT: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dirLeaf <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.capDir) dirLeaf <= sts.big;
    end
  end

  assign memReq    = (state == ST_RD_DIR) || (state == ST_WB_DIR) ||
                     (state == ST_RD_TBL) || (state == ST_WB_TBL);
  assign memWe     = (state == ST_WB_DIR) || (state == ST_WB_TBL);
  assign reqReady  = (state == ST_IDLE);
  assign doneValid = (state == ST_DONE) || (state == ST_FAULT);
  assign doneFault = (state == ST_FAULT);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              pagingOn,
  input  logic              wpOn,
  input  logic              pseOn,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] a20Mask,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic              memValid,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              doneValid,
  output logic              doneFault,
  output logic [ADDR_W-1:0] physPage,
  output logic              bigPage,
  output logic              permWrite,
  output logic              permUser,
  output logic [ERR_W-1:0]  faultCode,
  output logic [ADDR_W-1:0] faultAddr
);
  walkStrobe_t stb;
  walkStatus_t sts;

  pgwalk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pagingOn(pagingOn),
    .memValid(memValid), .sts(sts), .stb(stb), .memReq(memReq),
    .memWe(memWe), .reqReady(reqReady), .doneValid(doneValid),
    .doneFault(doneFault)
  );

  pgwalk_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .wpOn(wpOn), .pseOn(pseOn),
    .dirBase(dirBase), .a20Mask(a20Mask), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .physPage(physPage),
    .bigPage(bigPage), .permWrite(permWrite), .permUser(permUser),
    .faultCode(faultCode), .faultAddr(faultAddr)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgwalk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memReq,
  input logic              memWe,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memWdata,
  input logic              doneValid,
  input logic              doneFault,
  input logic [ADDR_W-1:0] physPage,
  input logic              bigPage,
  input logic [ADDR_W-1:0] faultAddr
);
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr) && $stable(memWe));

  a_r9_wb_accessed: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[B_A]);

  a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady && !doneValid |=> $stable(faultAddr));

  a_r3_big_align: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneFault && bigPage |-> physPage[BIG_SH-1:0] == '0);

  a_r4_page_align: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneFault |-> physPage[PG_SH-1:0] == '0);
endmodule

bind pgwalk_top pgwalk_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReq(memReq), .memWe(memWe), .memValid(memValid), .memAddr(memAddr),
  .memWdata(memWdata), .doneValid(doneValid), .doneFault(doneFault),
  .physPage(physPage), .bigPage(bigPage), .faultAddr(faultAddr)
);

// File: tb/pgwalk_tb.sv
module pgwalk_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0;
  logic        pagingOn = 1'b0, wpOn = 1'b0, pseOn = 1'b0;
  logic [31:0] reqAddr = '0, dirBase = '0, a20Mask = '1;
  logic        memValid;
  logic [31:0] memRdata;
  logic        reqReady, memReq, memWe, doneValid, doneFault, bigPage;
  logic        permWrite, permUser;
  logic [31:0] memAddr, memWdata, physPage, faultAddr;
  logic [2:0]  faultCode;

  pgwalk_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .pagingOn(pagingOn), .wpOn(wpOn), .pseOn(pseOn), .dirBase(dirBase),
    .a20Mask(a20Mask), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memValid(memValid), .memRdata(memRdata),
    .doneValid(doneValid), .doneFault(doneFault), .physPage(physPage),
    .bigPage(bigPage), .permWrite(permWrite), .permUser(permUser),
    .faultCode(faultCode), .faultAddr(faultAddr)
  );

  logic [31:0] mem [0:4095];
  int chkCnt = 0;
  int errCnt = 0;

  // expected values from the bench walk model
  bit          eFault, eBig, ePW, ePU;
  logic [2:0]  eCode;
  logic [31:0] ePage, eDirAddr;
  int          eN, nWb;
  logic [31:0] wbA [0:1];
  logic [31:0] wbV [0:1];

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory with one-cycle latency; sole writer of mem after setup
  task automatic memServe();
    forever begin
      @(posedge clk);
      if (!rstN) memValid <= 1'b0;
      else if (memReq && !memValid) begin
        memValid <= 1'b1;
        if (memWe) mem[memAddr[13:2]] = memWdata;
        else       memRdata <= mem[memAddr[13:2]];
      end else memValid <= 1'b0;
    end
  endtask

  function automatic void refWalk(input logic [31:0] lin, input bit w, u, pg, wp, pse,
                                  input logic [31:0] base, a20);
    logic [31:0] pde, pte, leaf, leafA, tA, nl;
    bit okU, okW, wOk;
    eN = 0; nWb = 0; eFault = 0; eCode = '0; ePage = '0; eBig = 0;
    ePW = 0; ePU = 0; eDirAddr = '0;
    if (!pg) begin
      ePage = lin & 32'hFFFFF000 & a20; ePW = 1; ePU = 1;
      return;
    end
    eDirAddr = ((base & 32'hFFFFF000) + {20'd0, lin[31:22], 2'b00}) & a20;
    pde = mem[eDirAddr[13:2]];
    eN = 1;
    if (!pde[0]) begin eFault = 1; eCode = {u, w, 1'b0}; return; end
    if (pde[7] && pse) begin
      okU = pde[2]; okW = pde[1]; leaf = pde; leafA = eDirAddr; eBig = 1;
    end else begin
      if (!pde[5]) begin
        eN++; wbA[nWb] = eDirAddr; wbV[nWb] = pde | 32'h20; nWb++;
      end
      tA = ((pde & 32'hFFFFF000) + {20'd0, lin[21:12], 2'b00}) & a20;
      pte = (nWb > 0 && tA[13:2] == eDirAddr[13:2]) ? wbV[0] : mem[tA[13:2]];
      eN++;
      if (!pte[0]) begin eFault = 1; eCode = {u, w, 1'b0}; return; end
      okU = pde[2] & pte[2]; okW = pde[1] & pte[1]; leaf = pte; leafA = tA;
    end
    wOk = u ? (okU && okW) : (okW || !wp);
    if ((u && !okU) || (w && !wOk)) begin eFault = 1; eCode = {u, w, 1'b1}; return; end
    nl = leaf | 32'h20 | (w ? 32'h40 : 32'h0);
    if (nl != leaf) begin eN++; wbA[nWb] = leafA; wbV[nWb] = nl; nWb++; end
    ePage = leaf & (eBig ? 32'hFFC00000 : 32'hFFFFF000) & a20;
    ePW = nl[6] && wOk;
    ePU = okU;
  endfunction

  task automatic runWalk(input string note, input logic [31:0] lin, input bit w, u, pg, wp, pse,
                         input logic [31:0] base, a20);
    int k;
    bit seen;
    logic [31:0] firstA;
    refWalk(lin, w, u, pg, wp, pse, base, a20);
    @(negedge clk);
    reqAddr = lin; reqWrite = w; reqUser = u; pagingOn = pg; wpOn = wp;
    pseOn = pse; dirBase = base; a20Mask = a20; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    k = 0; seen = 0; firstA = '0;
    while (1) begin
      if (memReq && !seen) begin seen = 1; firstA = memAddr; end
      if (doneValid || k >= 60) break;
      @(posedge clk); #1; k++;
    end
    chkEq({"R12 done seen ", note}, {31'd0, doneValid}, 32'd1);
    chkEq({"R12 latency ", note}, k, 2 * eN);
    if (!pg) chkEq({"R1 no access ", note}, {31'd0, seen}, 32'd0);
    else     chkEq({"R2 dir addr ", note}, firstA, eDirAddr);
    chkEq({eCode[0] ? "R6 fault flag " : "R5 fault flag ", note}, {31'd0, doneFault}, {31'd0, eFault});
    if (eFault) begin
      chkEq({eCode[0] ? "R6 code " : "R5 code ", note}, {29'd0, faultCode}, {29'd0, eCode});
      chkEq({"R10 addr ", note}, faultAddr, lin);
    end else begin
      chkEq({!pg ? "R1 page " : eBig ? "R3 page " : "R4 page ", note}, physPage, ePage);
      chkEq({"R3 size ", note}, {31'd0, bigPage}, {31'd0, eBig});
      chkEq({"R11 write perm ", note}, {31'd0, permWrite}, {31'd0, ePW});
      chkEq({"R6 user perm ", note}, {31'd0, permUser}, {31'd0, ePU});
    end
    for (int i = 0; i < nWb; i++)
      if (!(i == 0 && nWb == 2 && wbA[0][13:2] == wbA[1][13:2]))
        chkEq({"R9 R8 writeback ", note}, mem[wbA[i][13:2]], wbV[i]);
    @(posedge clk); #1;
  endtask

  initial begin
    memValid = 1'b0;
    memRdata = '0;
    void'($urandom(32'd7331));
    for (int i = 0; i < 4096; i++) mem[i] = $urandom;
    fork memServe(); join_none
    fork begin
      repeat (150000) @(posedge clk);
      errCnt++; chkCnt++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end join_none

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    chkEq("R12 reset ready", {31'd0, reqReady}, 32'd1);
    chkEq("R12 reset done", {31'd0, doneValid}, 32'd0);
    chkEq("R12 reset memReq", {31'd0, memReq}, 32'd0);

    // directed: 4 KB walk, entries at dir idx 1 and table idx 3
    mem[12'h401] = 32'h0000_2007;
    mem[12'h803] = 32'h00AB_C007;
    runWalk("R8 R9 clean user read", 32'h0040_3ABC, 0, 1, 1, 0, 0, 32'h0000_1000, '1);
    runWalk("R9 first write dirties", 32'h0040_3ABC, 1, 1, 1, 0, 0, 32'h0000_1FFF, '1);
    runWalk("R11 dirty read no wb", 32'h0040_3ABC, 0, 1, 1, 0, 0, 32'h0000_1000, '1);
    mem[12'h803] = 32'h00AB_C063;
    runWalk("R6 user no U bit", 32'h0040_3ABC, 0, 1, 1, 0, 0, 32'h0000_1000, '1);
    mem[12'h803] = 32'h00AB_C065;
    runWalk("R6 user write no RW", 32'h0040_3ABC, 1, 1, 1, 0, 0, 32'h0000_1000, '1);
    mem[12'h803] = 32'h00AB_C061;
    runWalk("R7 super write wp off", 32'h0040_3ABC, 1, 0, 1, 0, 0, 32'h0000_1000, '1);
    runWalk("R7 super write wp on", 32'h0040_3ABC, 1, 0, 1, 1, 0, 32'h0000_1000, '1);
    mem[12'h402] = 32'h0000_2006;
    runWalk("R5 dir absent", 32'h0080_0123, 1, 1, 1, 0, 0, 32'h0000_1000, '1);
    mem[12'h402] = 32'h0000_3027;
    mem[12'hC05] = 32'h1234_5006;
    runWalk("R5 table absent", 32'h0080_5123, 0, 0, 1, 0, 0, 32'h0000_1000, '1);
    mem[12'h701] = 32'h8A50_00E7;
    runWalk("R3 big page", 32'hC051_2345, 1, 1, 1, 1, 1, 32'h0000_1000, 32'hFFEF_FFFF);
    runWalk("R4 PS ignored pse off", 32'hC051_2345, 0, 0, 1, 0, 0, 32'h0000_1000, '1);
    mem[12'h702] = 32'h0040_0087;
    runWalk("R3 big clean wb", 32'hC080_0000, 0, 1, 1, 0, 1, 32'h0000_1000, '1);
    runWalk("R1 flat a20", 32'h0011_2345, 1, 1, 0, 1, 1, 32'h0000_1000, 32'hFFEF_FFFF);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] la, bs, am;
      bit w, u, pg, wp, ps;
      la = $urandom;
      bs = $urandom;
      am = ($urandom % 4 == 0) ? 32'hFFEF_FFFF : 32'hFFFF_FFFF;
      w  = $urandom % 2; u = $urandom % 2; wp = $urandom % 2; ps = $urandom % 2;
      pg = ($urandom % 8) != 0;
      for (int j = 0; j < 4; j++) begin
        int ix;
        ix = $urandom % 4096;
        mem[ix] = $urandom | (($urandom % 4 != 0) ? 32'h1 : 32'h0);
      end
      runWalk("random", la, w, u, pg, wp, ps, bs, am);
    end

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule